// File: doc/BRIEF.md
# Raster Video Fetch and Pixel Serializer

This block sits behind a CRT controller. On every character-clock strobe it takes the controller's refresh address, row address, horizontal sync, vertical sync and display-enable flags. From the two addresses it forms a video RAM byte address and fetches two neighbouring bytes. During the next character period it serializes those 16 bits into 16 pixel-clock output samples. Each pixel index goes through a 16-entry palette. The output is a 6-bit colour (three 3-level channels) and a sync flag.

One character period is 16 clocks. The period starts with the clock on which `cclk_en_i` is high. Three screen modes trade colour depth for horizontal resolution: 2 colours over 16 pixels, 4 colours over 8 pixels, and 16 colours over 4 pixels. A small write port sets the pen pointer, writes a colour into the palette or the border register, and records a pending mode. The pending mode becomes the active mode only at the end of horizontal sync, so a line never changes resolution partway through.

The video RAM is assumed to have a one-clock read latency. Data for the address shown in one clock is returned during the next clock.

Top module: `vid_fetch_serial`

## Requirements
- R1: On the clock after a strobe, `vram_addr_o` equals {ma[13:12], ra[2:0], ma[9:0], 0}, using the values captured at the strobe. In the clock after that, bit 0 is 1 and bits 15:1 are unchanged. Bits 15:1 change only at a strobe.
- R2: The character captured at one strobe is output during the next character period. Pixel k (0..15) is on `rgb_o` and `sync_o` from clock edge k+1 through clock edge k+2 counted from that next strobe edge, so pixel 15 is shown just after the following strobe edge. The bytes are fetched at phase 0 (high byte) and phase 1 (low byte).
- R3: Mode 2 gives 16 pixels. Pixel k is the single-bit pen from bit 7-(k mod 8) of the high byte (k<8) or of the low byte.
- R4: Mode 1 gives 8 pixels, each held for 2 clocks. Pixel p uses byte p/4 and n = p mod 4. The pen is {bit 7-n, bit 3-n}.
- R5: Mode 0 gives 4 pixels, each held for 4 clocks. Pixel p uses byte p/2 and n = p mod 2. The pen is {bit 7-n, bit 5-n, bit 3-n, bit 1-n}. Mode value 3 behaves exactly like mode 0.
- R6: A mode write (op 2, data[1:0]) only sets a pending value. It becomes active at the first strobe that samples hsync low after a strobe that sampled it high. A vsync edge does not apply it.
- R7: A pen write (op 0) stores a 5-bit pointer. A colour write (op 1) goes to the border register when bit 4 of the pointer is 1, and to palette entry pointer[3:0] otherwise.
- R8: A 5-bit colour c is stored as {b,g,r}, 2 bits each. Red is in bits 1:0 and is (c/3) mod 3. Green is in bits 3:2 and is (c/9) mod 3. Blue is in bits 5:4 and is c mod 3.
- R9: For a character with display enable low and no sync, all 16 samples carry the border colour and `sync_o` is 0.
- R10: For a character with hsync or vsync high, all 16 samples have `sync_o`=1 and `rgb_o`=0.
- R11: A write with op 3 changes no pointer, colour or mode.
- R12: While `rst_ni` is low, `vram_addr_o`, `rgb_o` and `sync_o` are 0. All palette entries, the border, the pointer and both mode values reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cclk_en_i | input | 1 | Character strobe, one clock in every 16 |
| ma_i | input | 14 | Controller refresh address |
| ra_i | input | 3 | Controller row address |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Display enable |
| vram_addr_o | output | 16 | Video RAM byte address |
| vram_data_i | input | 8 | Video RAM read data, one clock after the address |
| reg_we_i | input | 1 | Register write strobe |
| reg_op_i | input | 2 | 0 pen, 1 colour, 2 mode, 3 none |
| reg_data_i | input | 5 | Write data |
| rgb_o | output | 6 | Encoded colour {b,g,r} |
| sync_o | output | 1 | Sync level output |

## Verification
The hardest case to reach is a mode write that is pending but not yet active. Exercising it needs a write between two active characters, then a whole line with vsync but no hsync, then a second line with no sync at all, and only then an hsync falling edge. The bench runs exactly that sequence and checks every active pixel against the old decode until the hsync edge has passed. It then runs a near-exhaustive sweep of all four mode values over eight row addresses with scattered refresh bases, and pushes all 32 colour numbers through the border register.

// File: rtl/vf_pkg.sv
`timescale 1ns/1ps
package vf_pkg;
  localparam int MA_W    = 14;
  localparam int RA_W    = 3;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2 + RA_W + 10 + 1;
  localparam int WORD_W  = 2 * DATA_W;
  localparam int SLOT_W  = $clog2(WORD_W);
  localparam int PEN_N   = 16;
  localparam int PEN_W   = $clog2(PEN_N);
  localparam int CDATA_W = 5;
  localparam int COL_W   = 6;

  typedef enum logic [1:0] {OP_PEN = 2'd0, OP_COL = 2'd1, OP_MODE = 2'd2, OP_NOP = 2'd3} reg_op_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } ctl_t;

  function automatic logic [COL_W-1:0] col_encode(input logic [CDATA_W-1:0] c);
    logic [1:0] r, g, b;
    r = 2'((c / 5'd3) % 5'd3);
    g = 2'((c / 5'd9) % 5'd3);
    b = 2'(c % 5'd3);
    return {b, g, r};
  endfunction
endpackage

// File: rtl/vf_fetch.sv
`timescale 1ns/1ps
module vf_fetch
  import vf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cclk_en_i,
  input  logic [MA_W-1:0]   ma_i,
  input  logic [RA_W-1:0]   ra_i,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] vram_data_i,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [SLOT_W-1:0] slot_o,
  output ctl_t              ctl_o,
  output logic [WORD_W-1:0] word_o,
  output logic              hs_fall_o
);
  logic [ADDR_W-2:0] base_q;
  logic [SLOT_W-1:0] slot_q;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] b0_q, b1_q;
  logic              unused_ma;

  assign unused_ma = ^ma_i[11:10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      slot_q <= '0;
      ctl_q  <= '0;
    end else if (cclk_en_i) begin
      base_q <= {ma_i[13:12], ra_i, ma_i[9:0]};
      slot_q <= '0;
      ctl_q  <= ctl_i;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  // one-clock RAM latency: byte for phase p arrives in slot p+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b0_q <= '0;
      b1_q <= '0;
    end else begin
      if (slot_q == SLOT_W'(1)) b0_q <= vram_data_i;
      if (slot_q == SLOT_W'(2)) b1_q <= vram_data_i;
    end
  end

  assign vram_addr_o = {base_q, slot_q[0]};
  assign slot_o      = slot_q;
  assign ctl_o       = ctl_q;
  assign word_o      = {b0_q, b1_q};
  assign hs_fall_o   = cclk_en_i & ctl_q.hs & ~ctl_i.hs;
endmodule

// File: rtl/vf_regs.sv
`timescale 1ns/1ps
module vf_regs
  import vf_pkg::*;
#(
  parameter int N = PEN_N
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [1:0]                 op_i,
  input  logic [CDATA_W-1:0]         data_i,
  input  logic                       hs_fall_i,
  output logic [N-1:0][COL_W-1:0]    pal_o,
  output logic [COL_W-1:0]           border_o,
  output logic [1:0]                 mode_o
);
  logic [CDATA_W-1:0] pen_q;
  logic [1:0]         mode_nx_q, mode_q;
  logic [COL_W-1:0]   border_q;
  logic               col_we;

  assign col_we = we_i && (op_i == OP_COL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q     <= '0;
      mode_nx_q <= '0;
      mode_q    <= '0;
      border_q  <= '0;
    end else begin
      if (we_i && op_i == OP_PEN)  pen_q     <= data_i;
      if (we_i && op_i == OP_MODE) mode_nx_q <= data_i[1:0];
      if (col_we && pen_q[CDATA_W-1]) border_q <= col_encode(data_i);
      if (hs_fall_i) mode_q <= mode_nx_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pal_o[i] <= '0;
      else if (col_we && !pen_q[CDATA_W-1] && pen_q[PEN_W-1:0] == PEN_W'(i))
        pal_o[i] <= col_encode(data_i);
    end
  end

  assign border_o = border_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/vf_pix_dec.sv
`timescale 1ns/1ps
module vf_pix_dec
  import vf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        mode_i,
  output logic [PEN_W-1:0]  idx_o
);
  logic [DATA_W-1:0] by;
  logic [2:0]        n;

  // slot[3] selects the byte in every mode
  assign by = slot_i[SLOT_W-1] ? word_i[DATA_W-1:0] : word_i[WORD_W-1:DATA_W];

  always_comb begin
    case (mode_i)
      2'd2: begin
        n     = slot_i[2:0];
        idx_o = {3'b000, by[3'd7 - n]};
      end
      2'd1: begin
        n     = {1'b0, slot_i[2:1]};
        idx_o = {2'b00, by[3'd7 - n], by[3'd3 - n]};
      end
      default: begin
        n     = {2'b00, slot_i[2]};
        idx_o = {by[3'd7 - n], by[3'd5 - n], by[3'd3 - n], by[3'd1 - n]};
      end
    endcase
  end
endmodule

// File: rtl/vid_fetch_serial.sv
`timescale 1ns/1ps
module vid_fetch_serial
  import vf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cclk_en_i,
  input  logic [MA_W-1:0]    ma_i,
  input  logic [RA_W-1:0]    ra_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output logic [ADDR_W-1:0]  vram_addr_o,
  input  logic [DATA_W-1:0]  vram_data_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_op_i,
  input  logic [CDATA_W-1:0] reg_data_i,
  output logic [COL_W-1:0]   rgb_o,
  output logic               sync_o
);
  ctl_t                      in_ctl, fet_ctl, disp_ctl_q;
  logic [SLOT_W-1:0]         slot_w;
  logic [WORD_W-1:0]         fet_word, disp_word_q;
  logic                      hs_fall_w;
  logic [PEN_N-1:0][COL_W-1:0] pal_w;
  logic [COL_W-1:0]          border_w, rgb_d;
  logic [1:0]                mode_w;
  logic [PEN_W-1:0]          idx_w;
  logic                      sync_d;

  assign in_ctl = '{hs: hsync_i, vs: vsync_i, de: de_i};

  vf_fetch u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cclk_en_i  (cclk_en_i),
    .ma_i       (ma_i),
    .ra_i       (ra_i),
    .ctl_i      (in_ctl),
    .vram_data_i(vram_data_i),
    .vram_addr_o(vram_addr_o),
    .slot_o     (slot_w),
    .ctl_o      (fet_ctl),
    .word_o     (fet_word),
    .hs_fall_o  (hs_fall_w)
  );

  vf_regs #(.N(PEN_N)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .op_i     (reg_op_i),
    .data_i   (reg_data_i),
    .hs_fall_i(hs_fall_w),
    .pal_o    (pal_w),
    .border_o (border_w),
    .mode_o   (mode_w)
  );

  vf_pix_dec u_dec (
    .word_i(disp_word_q),
    .slot_i(slot_w),
    .mode_i(mode_w),
    .idx_o (idx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_word_q <= '0;
      disp_ctl_q  <= '0;
    end else if (cclk_en_i) begin
      disp_word_q <= fet_word;
      disp_ctl_q  <= fet_ctl;
    end
  end

  always_comb begin
    sync_d = disp_ctl_q.hs | disp_ctl_q.vs;
    if (sync_d)             rgb_d = '0;
    else if (!disp_ctl_q.de) rgb_d = border_w;
    else                    rgb_d = pal_w[idx_w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o  <= '0;
      sync_o <= 1'b0;
    end else begin
      rgb_o  <= rgb_d;
      sync_o <= sync_d;
    end
  end
endmodule

// File: rtl/vf_chk.sv
`timescale 1ns/1ps
module vf_chk
  import vf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cclk_en_i,
  input logic              hsync_i,
  input logic [ADDR_W-1:0] vram_addr_o,
  input logic [COL_W-1:0]  rgb_o,
  input logic              sync_o,
  input logic [1:0]        mode_i,
  input logic              cap_hs_i
);
  p_sync_blank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> rgb_o == '0);

  p_phase_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_en_i |=> !vram_addr_o[0]);

  p_phase_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_en_i ##1 !cclk_en_i) |=> vram_addr_o[0]);

  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cclk_en_i |=> $stable(vram_addr_o[ADDR_W-1:1]));

  p_mode_at_hs_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> $past(cclk_en_i && cap_hs_i && !hsync_i));
endmodule

bind vid_fetch_serial vf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cclk_en_i  (cclk_en_i),
  .hsync_i    (hsync_i),
  .vram_addr_o(vram_addr_o),
  .rgb_o      (rgb_o),
  .sync_o     (sync_o),
  .mode_i     (mode_w),
  .cap_hs_i   (fet_ctl.hs)
);

// File: tb/sim_vid_fetch_serial.sv
`timescale 1ns/1ps
module sim_vid_fetch_serial;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cclk_en;
  logic [13:0] ma;
  logic [2:0]  ra;
  logic        hs, vs, de;
  logic [15:0] addr;
  logic [7:0]  rdata;
  logic        we;
  logic [1:0]  op;
  logic [4:0]  wdata;
  logic [5:0]  rgb;
  logic        sync;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  vid_fetch_serial u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cclk_en_i(cclk_en), .ma_i(ma), .ra_i(ra),
    .hsync_i(hs), .vsync_i(vs), .de_i(de), .vram_addr_o(addr), .vram_data_i(rdata),
    .reg_we_i(we), .reg_op_i(op), .reg_data_i(wdata), .rgb_o(rgb), .sync_o(sync)
  );

  function automatic logic [7:0] memv(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  always @(posedge clk) rdata <= memv(addr);

  function automatic logic [5:0] enc(input int c);
    int r, g, b;
    r = (c / 3) % 3; g = (c / 9) % 3; b = c % 3;
    return 6'(b * 16 + g * 4 + r);
  endfunction

  // model state
  logic [5:0]  pal_m [16];
  logic [5:0]  bord_m;
  logic [4:0]  pen_m;
  logic [1:0]  mnext_m, mcur_m;
  logic [14:0] c_base;
  logic        c_hs, c_vs, c_de;
  logic [15:0] d_word;
  logic        d_hs, d_vs, d_de;
  logic [1:0]  d_mode;
  bit          pv;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] exp_pix(input int k);
    logic [7:0] by;
    int p, n, idx;
    if (d_hs || d_vs) return 7'h40;
    if (!d_de) return {1'b0, bord_m};
    case (d_mode)
      2'd2: begin
        p = k; by = (p < 8) ? d_word[15:8] : d_word[7:0]; n = p % 8;
        idx = int'(by[7-n]);
      end
      2'd1: begin
        p = k / 2; by = (p < 4) ? d_word[15:8] : d_word[7:0]; n = p % 4;
        idx = 2 * int'(by[7-n]) + int'(by[3-n]);
      end
      default: begin
        p = k / 4; by = (p < 2) ? d_word[15:8] : d_word[7:0]; n = p % 2;
        idx = 8 * int'(by[7-n]) + 4 * int'(by[5-n]) + 2 * int'(by[3-n]) + int'(by[1-n]);
      end
    endcase
    return {1'b0, pal_m[idx]};
  endfunction

  function automatic string tagof(input string ovr);
    if (ovr != "") return ovr;
    if (d_hs || d_vs) return "R10";
    if (!d_de) return "R9";
    if (d_mode == 2'd2) return "R3";
    if (d_mode == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic reg_wr(input logic [1:0] o, input logic [4:0] d);
    @(negedge clk);
    we = 1'b1; op = o; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (o)
      2'd0: pen_m = d;
      2'd1: if (pen_m[4]) bord_m = enc(int'(d)); else pal_m[pen_m[3:0]] = enc(int'(d));
      2'd2: mnext_m = d[1:0];
      default: ;
    endcase
    pv = 0;
  endtask

  task automatic step_char(input logic [13:0] m, input logic [2:0] r, input bit h,
                           input bit v, input bit e, input string ovr);
    logic [6:0] e15;
    bit         pv_old;
    string      t_old;
    @(negedge clk);
    if (pv) begin
      e15 = exp_pix(14);
      chk({sync, rgb} == e15, tagof(ovr), {25'd0, sync, rgb}, {25'd0, e15});
    end
    cclk_en = 1'b1; ma = m; ra = r; hs = h; vs = v; de = e;
    if (c_hs && !h) mcur_m = mnext_m;
    e15 = exp_pix(15);
    t_old = tagof(ovr);
    pv_old = pv;
    d_word = {memv({c_base, 1'b0}), memv({c_base, 1'b1})};
    d_hs = c_hs; d_vs = c_vs; d_de = c_de; d_mode = mcur_m;
    c_base = {m[13:12], r, m[9:0]};
    c_hs = h; c_vs = v; c_de = e;
    @(negedge clk);
    cclk_en = 1'b0;
    if (pv_old) chk({sync, rgb} == e15, {"R2/", t_old}, {25'd0, sync, rgb}, {25'd0, e15});
    chk(addr == {c_base, 1'b0}, "R1", {16'd0, addr}, {16'd0, c_base, 1'b0});
    pv = 1;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      if (j == 1) chk(addr == {c_base, 1'b1}, "R1", {16'd0, addr}, {16'd0, c_base, 1'b1});
      e15 = exp_pix(j - 1);
      chk({sync, rgb} == e15, tagof(ovr), {25'd0, sync, rgb}, {25'd0, e15});
    end
  endtask

  task automatic line(input int row, input logic [13:0] base, input bit v, input bit use_hs,
                      input string ovr, input int midw);
    string t;
    t = ovr;
    for (int ch = 0; ch < 8; ch++) begin
      step_char(base + 14'(ch), 3'(row), use_hs && ch == 6, v, ch < 5, t);
      if (midw >= 0 && ch == 1) begin
        reg_wr(2'd2, 5'(midw));
        t = "R6";
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cclk_en = 1'b0; ma = '0; ra = '0; hs = 1'b0; vs = 1'b0; de = 1'b0;
    we = 1'b0; op = '0; wdata = '0;
    for (int i = 0; i < 16; i++) pal_m[i] = '0;
    bord_m = '0; pen_m = '0; mnext_m = '0; mcur_m = '0;
    c_base = '0; c_hs = 0; c_vs = 0; c_de = 0;
    d_word = '0; d_hs = 0; d_vs = 0; d_de = 0; d_mode = '0; pv = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(addr == 16'd0, "R12", {16'd0, addr}, 0);
    chk(rgb == 6'd0, "R12", {26'd0, rgb}, 0);
    chk(sync == 1'b0, "R12", {31'd0, sync}, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R12: reset palette/border all zero, mode 0
    line(0, 14'h0040, 0, 1, "R12", -1);

    // R8: every colour number through the border register
    for (int c = 0; c < 32; c++) begin
      reg_wr(2'd0, 5'h10);
      reg_wr(2'd1, 5'(c));
      step_char(14'h0, 3'd0, 0, 0, 0, "R8");
      step_char(14'h0, 3'd0, 0, 0, 0, "R8");
    end

    // palette set-up
    for (int p = 0; p < 16; p++) begin
      reg_wr(2'd0, 5'(p));
      reg_wr(2'd1, 5'((p * 7 + 3) % 32));
    end
    reg_wr(2'd0, 5'h10);
    reg_wr(2'd1, 5'd9);

    // R7: pointer bit 4 routes to border, pen 3 keeps its colour
    reg_wr(2'd0, 5'h13);
    reg_wr(2'd1, 5'd20);
    line(1, 14'h0123, 0, 1, "R7", -1);
    line(2, 14'h0223, 0, 1, "R7", -1);
    reg_wr(2'd0, 5'h03);
    reg_wr(2'd1, 5'd26);
    line(3, 14'h0323, 0, 1, "R7", -1);

    // R11: op 3 writes must not move the pointer, a colour or the mode
    reg_wr(2'd0, 5'h05);
    reg_wr(2'd3, 5'h12);
    reg_wr(2'd1, 5'd17);
    reg_wr(2'd3, 5'h1E);
    line(4, 14'h2A00, 0, 1, "R11", -1);
    line(5, 14'h2A08, 0, 1, "R11", -1);

    // R6: pending mode survives a vsync-only line and a sync-free line
    line(0, 14'h0100, 0, 0, "", 2);
    line(1, 14'h0110, 1, 0, "R6", -1);
    line(2, 14'h0120, 0, 0, "R6", -1);
    line(3, 14'h0130, 0, 1, "R6", -1);
    line(4, 14'h0140, 0, 1, "R6", -1);

    // sweep of all mode values over rows and scattered bases
    for (int mi = 0; mi < 4; mi++) begin
      int m;
      m = (mi == 0) ? 1 : (mi == 1) ? 0 : (mi == 2) ? 3 : 2;
      reg_wr(2'd2, 5'(m));
      line(7, 14'h3F00, 0, 1, "", -1);
      for (int row = 0; row < 8; row++)
        line(row, 14'((row * 1337 + m * 4099) & 16383), 0, 1, "", -1);
      line(0, 14'h1555, 1, 1, "R10", -1);
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule